// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block collects external interrupt lines and turns selected signal edges into latched pending flags and single-cycle interrupt pulses. Forty lines are split over two banks: bank 0 holds 32 lines and bank 1 holds 8. For each line, software sets an interrupt enable, an event enable (stored only), a rising-edge select, a falling-edge select and a software trigger bit, and it reads and clears a pending flag. Sixteen asynchronous line inputs feed bank 0 lines 0 to 15 through a two-stage synchronizer and an edge detector. All other lines become pending only through the software trigger.

Some lines are fixed direct lines. Their edge selects and software trigger bits cannot be set, and their interrupt enable comes out of reset set. Software reaches the registers through a plain 32-bit write/read port with a combinational read path. Each time a pending flag is set, the line's interrupt output pulses high for one clock cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, bank 0 interrupt enable reads 0xFF820000, bank 1 interrupt enable reads 0x00000087, every other register reads 0 and all interrupt outputs are low.
- R2: Register offsets per bank are: enable 0x00, event enable 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14, with bank 1 at the same offsets plus 0x20. Any other offset, or an address with bits [1:0] not zero, reads 0 and ignores writes.
- R3: Writes to the interrupt enable and event enable registers keep only the bank's valid lines: all 32 bits in bank 0 and bits [7:0] in bank 1.
- R4: Writes to the rising select, falling select, software trigger and pending registers affect only configurable bits, which are the valid bits outside the fixed masks 0xFF820000 (bank 0) and 0x00000087 (bank 1). Fixed bits of the select and trigger registers read 0.
- R5: When an enabled line input rises and its rising select bit is 1, the pending bit is set. Counting from the input change, the pending bit reads 1 and the line's output is high after the third rising clock edge. The output is low again one cycle later.
- R6: A falling input sets the pending bit only when the falling select bit is 1. An edge opposite to the selected one, or an edge with no select bit set, changes nothing.
- R7: An input edge on a line whose interrupt enable bit is 0 never sets its pending bit or pulses its output.
- R8: A software trigger write marks pending, and pulses the output of, every bit that is written 1, configurable, previously 0 in the trigger register, enabled and not already pending. The output is high in the cycle after the write. The trigger register then holds the configurable part of the written value.
- R9: Writing 1 to a set pending bit clears that bit and the matching software trigger bit. Writing 0 leaves the bit unchanged.
- R10: If a selected, enabled edge arrives in the same cycle as a write that clears that line's pending bit, the bit stays set and the output pulses.
- R11: Line input i drives bank 0 line i for i from 0 to 15. Output bit 32+j is bank 1 line j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| line_in | input | 16 | Asynchronous external line inputs |
| irq_pulse | output | 40 | Per-line interrupt pulse, bank 0 in [31:0], bank 1 in [39:32] |

## Verification
A hardware edge on a line and a software write to the same line's pending register can fall in the same clock cycle. The bench provokes this by raising line 3 and starting a clear write to bit 3 on the cycle the synchronized edge reaches the bank. It then requires the pending bit to read back as set and output 3 to pulse. A second clear write with no edge present shows that the clear path works on its own.

// File: rtl/ext_irq_pkg.sv
// Package: shared register indices and geometry for the external
// interrupt controller. Assumes word-aligned 32-bit registers.
package ext_irq_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned NUM_BANKS  = 2;
    localparam int unsigned BANK_SHIFT = 5;   // bank stride 0x20

    typedef enum logic [2:0] {
        RI_IMASK  = 3'd0,
        RI_EMASK  = 3'd1,
        RI_RISE   = 3'd2,
        RI_FALL   = 3'd3,
        RI_SWTRIG = 3'd4,
        RI_PEND   = 3'd5
    } reg_idx_e;

    localparam logic [2:0] LAST_IDX = 3'd5;
endpackage

// File: rtl/ext_irq_sync.sv
// Module: two-flop synchronizer plus edge detector for asynchronous
// line inputs. Assumes inputs are level signals held at least two clock
// cycles. rise/fall are one-cycle strobes on the synchronized signal.
module ext_irq_sync #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    // Purpose: sample the inputs twice and keep the previous synced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: compare the current and previous synchronized values per line.
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] & prev_q[i];
    end

    // R5: a rise strobe lasts exactly one cycle
    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/ext_irq_decode.sv
// Module: address decoder. Splits a byte address into a bank number and
// a register index and flags legal accesses. Assumes only aligned word
// accesses are legal. All other addresses are reported as misses.
module ext_irq_decode
    import ext_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              bank,
    output logic [2:0]        idx
);
    logic aligned, in_window;

    // Purpose: derive the bank and index and check that the offset is defined.
    always_comb begin
        aligned   = (addr[1:0] == 2'b00);
        in_window = (addr[ADDR_W-1:BANK_SHIFT+1] == '0);
        bank      = addr[BANK_SHIFT];
        idx       = addr[4:2];
        hit       = aligned && in_window && (idx <= LAST_IDX);
    end
endmodule

// File: rtl/ext_irq_bank.sv
// Module: one bank of interrupt lines with its registers, edge capture,
// software trigger and write-one-to-clear pending logic. Assumes rise/fall
// are single-cycle synchronized strobes. irq_out is registered, so it is
// high in the same cycle the new pending bit becomes visible.
module ext_irq_bank
    import ext_irq_pkg::*;
#(
    parameter int unsigned LINES = 32,
    parameter logic [31:0] FIXED = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_idx,
    output logic [31:0] rd_data,
    input  logic [31:0] rise_in,
    input  logic [31:0] fall_in,
    output logic [31:0] irq_out
);
    localparam logic [63:0] VALID64 = (64'd1 << LINES) - 64'd1;
    localparam logic [31:0] VALID   = VALID64[31:0];
    localparam logic [31:0] CFG     = VALID & ~FIXED;

    logic [31:0] imr_q, emr_q, rtsr_q, ftsr_q, swtr_q, pr_q, irq_q;
    logic [31:0] edge_set, sw_req, sw_set, clr, pr_d, swtr_d;
    logic        wr_sw, wr_pend;

    // Purpose: compute the new pending set from edges, triggers and clears.
    always_comb begin
        wr_sw    = wr_en && (wr_idx == RI_SWTRIG);
        wr_pend  = wr_en && (wr_idx == RI_PEND);
        edge_set = imr_q & VALID & ((rise_in & rtsr_q) | (fall_in & ftsr_q));
        sw_req   = wr_data & CFG;
        sw_set   = wr_sw ? (sw_req & ~swtr_q & imr_q & ~pr_q) : '0;
        clr      = wr_pend ? (pr_q & wr_data & CFG) : '0;
        pr_d     = (pr_q & ~clr) | edge_set | sw_set;
        swtr_d   = wr_sw ? sw_req : (swtr_q & ~clr);
    end

    // Purpose: hold the configuration registers and take masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= FIXED & VALID;
            emr_q  <= '0;
            rtsr_q <= '0;
            ftsr_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                RI_IMASK: imr_q  <= wr_data & VALID;
                RI_EMASK: emr_q  <= wr_data & VALID;
                RI_RISE:  rtsr_q <= wr_data & CFG;
                RI_FALL:  ftsr_q <= wr_data & CFG;
                default:  ;
            endcase
        end
    end

    // Purpose: update the pending and trigger state and register the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q   <= '0;
            swtr_q <= '0;
            irq_q  <= '0;
        end else begin
            pr_q   <= pr_d;
            swtr_q <= swtr_d;
            irq_q  <= edge_set | sw_set;
        end
    end

    // Purpose: read multiplexer for the register index.
    always_comb begin
        case (rd_idx)
            RI_IMASK:  rd_data = imr_q;
            RI_EMASK:  rd_data = emr_q;
            RI_RISE:   rd_data = rtsr_q;
            RI_FALL:   rd_data = ftsr_q;
            RI_SWTRIG: rd_data = swtr_q;
            RI_PEND:   rd_data = pr_q;
            default:   rd_data = '0;
        endcase
    end

    assign irq_out = irq_q;

    // R7: a line that was disabled cannot become newly pending
    a_r7_masked_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pr_q & ~$past(pr_q) & ~$past(imr_q)) == '0));

    // R5: every pulse is matched by a set pending bit
    a_r5_pulse_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_q & ~pr_q) == '0));

    // R9: pending bits only drop after a pending-register write
    a_r9_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((pr_q & $past(pr_q)) == $past(pr_q)));

    // R8: a trigger bit that was already 1 does not pulse again
    a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sw |=> ((irq_q & $past(swtr_q) & ~$past(rise_in | fall_in)) == '0));

    // R10: a selected edge wins over a simultaneous clear
    a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && ((rise_in & rtsr_q & imr_q) != '0))
        |=> ((pr_q & $past(rise_in & rtsr_q & imr_q)) == $past(rise_in & rtsr_q & imr_q)));
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: top level of the edge-triggered external interrupt controller.
// Synchronizes the line inputs, decodes the register port and instantiates
// one bank per line group. Assumes aligned 32-bit accesses only, and that
// EDGE_LINES is at most BANK0_LINES.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BANK0_LINES = 32,
    parameter int unsigned BANK1_LINES = 8,
    parameter logic [31:0] BANK0_FIXED = 32'hFF82_0000,
    parameter logic [31:0] BANK1_FIXED = 32'h0000_0087,
    parameter int unsigned EDGE_LINES  = 16,
    localparam int unsigned OUT_W      = BANK0_LINES + BANK1_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [EDGE_LINES-1:0] line_in,
    output logic [OUT_W-1:0]  irq_pulse
);
    logic [EDGE_LINES-1:0] rise_n, fall_n;
    logic [31:0]           rise_w, fall_w;
    logic                  hit, bank_sel;
    logic [2:0]            idx;
    logic [31:0]           bank_rd  [NUM_BANKS];
    logic [31:0]           bank_irq [NUM_BANKS];

    ext_irq_sync #(.N(EDGE_LINES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(line_in),
        .rise(rise_n), .fall(fall_n)
    );

    ext_irq_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr(bus_addr), .hit(hit), .bank(bank_sel), .idx(idx)
    );

    // R11: input strobes land on bank 0 lines 0..EDGE_LINES-1
    assign rise_w = 32'(rise_n);
    assign fall_w = 32'(fall_n);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned LN = (b == 0) ? BANK0_LINES : BANK1_LINES;
        localparam logic [31:0] FX = (b == 0) ? BANK0_FIXED : BANK1_FIXED;
        logic wr_b;
        assign wr_b = bus_wen && hit && (bank_sel == 1'(b));
        ext_irq_bank #(.LINES(LN), .FIXED(FX)) i_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_b), .wr_idx(idx), .wr_data(bus_wdata),
            .rd_idx(idx), .rd_data(bank_rd[b]),
            .rise_in((b == 0) ? rise_w : 32'h0),
            .fall_in((b == 0) ? fall_w : 32'h0),
            .irq_out(bank_irq[b])
        );
    end

    // Purpose: select the read data of the addressed bank, or 0 on a miss.
    always_comb begin
        bus_rdata = hit ? bank_rd[bank_sel] : '0;
    end

    assign irq_pulse = {bank_irq[1][BANK1_LINES-1:0], bank_irq[0][BANK0_LINES-1:0]};

    // R1: outputs are quiet in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_pulse == '0));
endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] line_in = '0;
    logic [39:0] irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_in(line_in), .irq_pulse(irq_pulse)
    );

    // {address, write data, expected read-back}
    localparam logic [71:0] VEC [0:10] = '{
        {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R3
        {8'h20, 32'hFFFF_FFFF, 32'h0000_00FF},  // R3
        {8'h04, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R3
        {8'h24, 32'h1234_5678, 32'h0000_0078},  // R3
        {8'h08, 32'hFFFF_FFFF, 32'h007D_FFFF},  // R4
        {8'h28, 32'hFFFF_FFFF, 32'h0000_0078},  // R4
        {8'h0C, 32'hFFFF_FFFF, 32'h007D_FFFF},  // R4
        {8'h2C, 32'h0000_000F, 32'h0000_0008},  // R4
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R2
        {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000},  // R2
        {8'h01, 32'h0000_0000, 32'h0000_0000}   // R2
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one line, then land on the negedge after the third posedge
    task automatic edge_line(input int n, input logic v);
        @(negedge clk);
        line_in[n] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2/R3/R4 register table walk
        for (int i = 0; i < 11; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], got);
            chk("R2/R3/R4 table", got, VEC[i][31:0]);
        end
        rd(8'h00, got); chk("R2 unaligned write ignored", got, 32'hFFFF_FFFF);

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk("R1 irq low", irq_pulse, 40'h0);
        rd(8'h00, got); chk("R1 enable bank0", got, 32'hFF82_0000);
        rd(8'h20, got); chk("R1 enable bank1", got, 32'h0000_0087);
        rd(8'h08, got); chk("R1 rising select", got, 32'h0);
        rd(8'h14, got); chk("R1 pending", got, 32'h0);

        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0000_0008);
        wr(8'h0C, 32'h0000_0020);

        // R5 rising edge on line 3
        edge_line(3, 1'b1);
        chk("R5 pulse line 3", irq_pulse, 40'h8);
        rd(8'h14, got); chk("R5 pending line 3", got, 32'h8);
        @(negedge clk);
        chk("R5 pulse one cycle", irq_pulse, 40'h0);

        // R6 falling edge on a rising-only line does nothing
        edge_line(3, 1'b0);
        chk("R6 opposite edge no pulse", irq_pulse, 40'h0);
        rd(8'h14, got); chk("R6 opposite edge pending kept", got, 32'h8);

        // R10 edge coincides with a clear of the same bit
        @(negedge clk); line_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 8'h14; bus_wdata = 32'h8; bus_wen = 1'b1;
        @(negedge clk); bus_wen = 1'b0;
        chk("R10 pulse on overlap", irq_pulse, 40'h8);
        rd(8'h14, got); chk("R10 pending stays set", got, 32'h8);
        wr(8'h14, 32'h8);
        rd(8'h14, got); chk("R10/R9 plain clear", got, 32'h0);

        // R6 falling select on line 5
        edge_line(5, 1'b1);
        chk("R6 rise not selected", irq_pulse, 40'h0);
        edge_line(5, 1'b0);
        chk("R6 fall pulse line 5", irq_pulse, 40'h20);
        rd(8'h14, got); chk("R6 fall pending line 5", got, 32'h20);
        wr(8'h14, 32'h20);

        // R7 masked line 6
        wr(8'h00, 32'hFFFF_FFBF);
        wr(8'h08, 32'h0000_0048);
        edge_line(6, 1'b1);
        chk("R7 masked no pulse", irq_pulse, 40'h0);
        rd(8'h14, got); chk("R7 masked no pending", got, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);

        // R8 software trigger
        wr(8'h10, 32'h0000_0100);
        chk("R8 sw pulse line 8", irq_pulse, 40'h100);
        rd(8'h14, got); chk("R8 sw pending", got, 32'h100);
        wr(8'h10, 32'h0000_0300);
        chk("R8 only new bit pulses", irq_pulse, 40'h200);
        rd(8'h14, got); chk("R8 pending 8 and 9", got, 32'h300);
        wr(8'h10, 32'h0002_0000);
        chk("R4 fixed line no sw pulse", irq_pulse, 40'h0);
        rd(8'h10, got); chk("R4/R8 trigger takes written cfg value", got, 32'h0);
        wr(8'h30, 32'h0000_0008);
        chk("R11 bank1 line 3 on bit 35", irq_pulse, 40'h08_0000_0000);
        rd(8'h34, got); chk("R8 bank1 pending", got, 32'h8);
        wr(8'h00, 32'hFFFF_FBFF);
        wr(8'h10, 32'h0000_0400);
        chk("R8 masked sw no pulse", irq_pulse, 40'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0000_0300);
        chk("R8 already pending no pulse", irq_pulse, 40'h0);

        // R9 write-one-to-clear
        wr(8'h14, 32'h0);
        rd(8'h14, got); chk("R9 write 0 no effect", got, 32'h300);
        wr(8'h14, 32'h100);
        rd(8'h14, got); chk("R9 clear bit 8", got, 32'h200);
        rd(8'h10, got); chk("R9 trigger bit 8 cleared", got, 32'h200);
        wr(8'h34, 32'h8);
        rd(8'h34, got); chk("R9 bank1 cleared", got, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule